// File: doc/BRIEF.md
# Address-Filtering HDLC Bit Receiver

This block recovers frames from a serial line. Each bit arrives on `rx_bit` and counts only in a cycle where `rx_bit_vld` is high. With `raw_mode` low the block runs in framed mode. It looks for flag octets and deletes stuffed zeros. It runs a 16-bit check sequence over each frame. It keeps a frame only when the first octet of the frame equals `match_addr` or the all-ones broadcast value. With `raw_mode` high every valid bit is packed into octets and forwarded unchanged.

Kept octets leave on a single-cycle strobe, `byte_vld` with `byte_data`. The address octet and both check octets are delivered as well, so the sink can store the whole frame. The end of each kept frame is marked by a separate `frame_end` pulse. That pulse carries either a good-check indication or a discard indication. The sink is expected to be a receive FIFO.

The controller is a five-state machine:
- HUNT waits for a flag.
- ADDR collects the address octet.
- BODY forwards a matched frame.
- SKIP ignores a frame whose address does not match.
- RAW packs bits without any framing.

Transitions:
- open (HUNT→ADDR on a flag)
- restart (ADDR, BODY or SKIP →ADDR on a flag)
- hit (ADDR→BODY on a matching address)
- miss (ADDR→SKIP on any other address)
- abort (ADDR, BODY or SKIP →HUNT on seven ones)
- to_raw (any framed state →RAW when `raw_mode` rises)
- to_framed (RAW→HUNT when `raw_mode` falls)

Top module: `hdlc_addr_rx`

## Requirements
- R1: After reset `byte_vld`, `byte_data`, `frame_end`, `frame_crc_ok` and `frame_discard` are all 0, and the framed receiver ignores everything until it sees a flag.
- R2: In framed mode, the flag pattern 0,1,1,1,1,1,1,0 (in line order) is never delivered. Every octet between two flags is delivered, including the address octet and the two check octets. The first bit received is octet bit 0. Each octet appears on `byte_vld` for one cycle and `byte_data` is 0 whenever `byte_vld` is low. `byte_vld` and `frame_end` are never high in the same cycle.
- R3: In framed mode, a 0 received right after five consecutive 1s is deleted before packing.
- R4: For a kept frame, `frame_crc_ok` pulses together with `frame_end` when the frame is well formed and the check register holds 0xF0B8 after all bits before the closing flag. The check uses the reflected polynomial 0x8408, starts at 0xFFFF and is fed LSB first. The transmitted check value is the complement of the register, sent low octet first. A wrong check gives `frame_end` with `frame_crc_ok` low and `frame_discard` low.
- R5: A frame is kept when its first octet equals `match_addr` or 0xFF. Any other frame produces no `byte_vld` and no `frame_end`.
- R6: A seventh consecutive 1 aborts the frame. A kept frame then ends with `frame_end` and `frame_discard` high and `frame_crc_ok` low. In the address or ignore phase an abort produces no output. After an abort a new flag is needed.
- R7: A kept frame that closes with fewer than 3 octets, or with a bit count that is not a multiple of 8, ends with `frame_end` and `frame_discard` high and `frame_crc_ok` low.
- R8: A flag that arrives before the address octet is complete produces no output and restarts address collection.
- R9: One flag can close a frame and open the next. The second frame is then received with its own address decision and check.
- R10: In raw mode every 8 valid bits form one octet, with the first bit at bit 0, whatever the pattern. Flags, stuffing and addresses have no effect and `frame_end` stays low.
- R11: A change of `raw_mode` drops any partial octet and any open frame without a `frame_end`. The bit offered in the cycle of the change is ignored. A switch into framed mode waits for a flag.
- R12: `rx_bit` has no effect in cycles where `rx_bit_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_bit | input | 1 | Serial line bit |
| rx_bit_vld | input | 1 | Qualifies `rx_bit` for this cycle |
| raw_mode | input | 1 | 1 selects raw packing, 0 selects framed reception |
| match_addr | input | 8 | Station address compared with the first octet |
| byte_vld | output | 1 | One-cycle strobe for a delivered octet |
| byte_data | output | 8 | Delivered octet, 0 when `byte_vld` is low |
| frame_end | output | 1 | One-cycle end marker of a kept frame |
| frame_crc_ok | output | 1 | With `frame_end`: frame well formed and check correct |
| frame_discard | output | 1 | With `frame_end`: frame aborted, too short or misaligned |

## Verification
One flag can do two jobs in a single cycle when two frames share it. It closes the first frame, producing the end marker with its check verdict. In the same cycle it reloads the check register and the octet packer for the next frame. The bench provokes this by sending two frames back to back with only one flag between them. The per-cycle model then expects the first frame's end pulse on the flag's cycle and the second frame's address decision and good verdict, with no state carried over. A second overlap is tested too: a mode change in the same cycle as a valid bit. The bench judges it by the absence of any octet or end pulse built from that bit.

// File: rtl/hdlc_rx_pkg.sv
package hdlc_rx_pkg;

    localparam int          OCT_W      = 8;       // bits per octet
    localparam int          STUFF_RUN  = 5;       // ones before a stuffed zero
    localparam int          CRC_W      = 16;
    localparam logic [15:0] CRC_POLY   = 16'h8408; // reflected CCITT polynomial
    localparam logic [15:0] CRC_INIT   = 16'hFFFF;
    localparam logic [15:0] CRC_GOOD   = 16'hF0B8; // residue of a correct frame
    localparam int          MIN_OCTETS = 3;       // address plus two check octets

    typedef enum logic [2:0] {
        RX_HUNT,
        RX_ADDR,
        RX_BODY,
        RX_SKIP,
        RX_RAW
    } rx_state_t;

endpackage

// File: rtl/hdlc_bit_class.sv
// Tracks runs of ones on the line and classifies each valid bit as
// data to keep, a stuffed zero to drop, a flag, or an abort.
module hdlc_bit_class #(
    parameter int RUN = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    input  logic bit_i,
    output logic push_o,
    output logic flag_o,
    output logic abort_o
);
    localparam int MAXC = RUN + 2;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] ones_q;

    always_comb begin
        push_o  = 1'b0;
        flag_o  = 1'b0;
        abort_o = 1'b0;
        if (en) begin
            if (bit_i) begin
                push_o  = (ones_q < CW'(RUN));
                abort_o = (ones_q == CW'(RUN + 1));
            end else begin
                push_o = (ones_q != CW'(RUN)) && (ones_q != CW'(RUN + 1));
                flag_o = (ones_q == CW'(RUN + 1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            ones_q <= '0;
        end else if (en) begin
            if (!bit_i)                    ones_q <= '0;
            else if (ones_q != CW'(MAXC))  ones_q <= ones_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_bit_delay.sv
// Holds the newest DEPTH kept bits so that the leading part of a closing
// flag can be withdrawn before it reaches the packer and the check.
module hdlc_bit_delay #(
    parameter int DEPTH = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic push,
    input  logic bit_i,
    output logic commit_o,
    output logic bit_o
);
    localparam int FW = $clog2(DEPTH + 1);

    logic [DEPTH-1:0] hold_q;
    logic [FW-1:0]    fill_q;
    logic             full;

    assign full     = (fill_q == FW'(DEPTH));
    assign commit_o = push && full;
    assign bit_o    = hold_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n || clr)       fill_q <= '0;
        else if (push && !full)  fill_q <= fill_q + 1'b1;
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic nxt_bit;
        if (i == DEPTH - 1) begin : g_top
            assign nxt_bit = bit_i;
        end else begin : g_mid
            assign nxt_bit = hold_q[i+1];
        end
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                hold_q[i] <= 1'b0;
            end else if (push) begin
                if (full)                     hold_q[i] <= nxt_bit;
                else if (fill_q == FW'(i))    hold_q[i] <= bit_i;
            end
        end
    end

endmodule

// File: rtl/hdlc_crc_acc.sv
// Bit-serial reflected check register.
module hdlc_crc_acc #(
    parameter int           W    = 16,
    parameter logic [W-1:0] POLY = 16'h8408,
    parameter logic [W-1:0] INIT = 16'hFFFF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic         upd,
    input  logic         bit_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] crc_q;
    logic         fb;

    assign fb    = crc_q[0] ^ bit_i;
    assign crc_o = crc_q;

    always_ff @(posedge clk) begin
        if (!rst_n || init) crc_q <= INIT;
        else if (upd)       crc_q <= (crc_q >> 1) ^ ({W{fb}} & POLY);
    end

endmodule

// File: rtl/hdlc_octet_pack.sv
// Packs bits LSB first; the first bit of an octet lands in bit 0.
module hdlc_octet_pack #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         shift,
    input  logic         bit_i,
    output logic         full_o,
    output logic [W-1:0] octet_o,
    output logic         partial_o
);
    localparam int CW = $clog2(W);

    logic [W-1:0]  sr_q;
    logic [CW-1:0] cnt_q;

    assign octet_o   = {bit_i, sr_q[W-1:1]};
    assign full_o    = shift && (cnt_q == CW'(W - 1));
    assign partial_o = (cnt_q != '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            cnt_q <= '0;
        end else if (shift) begin
            sr_q  <= octet_o;
            cnt_q <= full_o ? '0 : cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/hdlc_addr_rx.sv
module hdlc_addr_rx
    import hdlc_rx_pkg::*;
#(
    parameter int               OCT_W      = hdlc_rx_pkg::OCT_W,
    parameter int               STUFF_RUN  = hdlc_rx_pkg::STUFF_RUN,
    parameter int               MIN_OCTETS = hdlc_rx_pkg::MIN_OCTETS,
    parameter logic [OCT_W-1:0] BCAST_ADDR = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_bit,
    input  logic             rx_bit_vld,
    input  logic             raw_mode,
    input  logic [OCT_W-1:0] match_addr,
    output logic             byte_vld,
    output logic [OCT_W-1:0] byte_data,
    output logic             frame_end,
    output logic             frame_crc_ok,
    output logic             frame_discard
);
    localparam int HOLD = STUFF_RUN + 1;
    localparam int NB_W = $clog2(MIN_OCTETS + 1);

    rx_state_t st_q, st_d;

    logic in_raw, mode_chg, bv, fr_bv, raw_bv, collecting;
    logic is_push, is_flag, is_abort;
    logic dly_commit, dly_bit;
    logic pk_clr, pk_shift, pk_bit, pk_full, pk_partial;
    logic [OCT_W-1:0] pk_octet;
    logic [CRC_W-1:0] crc_val;
    logic addr_hit;
    logic [NB_W-1:0] nb_q;

    logic             nx_vld, nx_end, nx_ok, nx_disc;
    logic [OCT_W-1:0] nx_data;

    assign in_raw     = (st_q == RX_RAW);
    assign mode_chg   = raw_mode ^ in_raw;
    assign bv         = rx_bit_vld && !mode_chg;
    assign fr_bv      = bv && !in_raw;
    assign raw_bv     = bv && in_raw;
    assign collecting = (st_q == RX_ADDR) || (st_q == RX_BODY);

    hdlc_bit_class #(.RUN(STUFF_RUN)) i_class (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (mode_chg || in_raw),
        .en      (fr_bv),
        .bit_i   (rx_bit),
        .push_o  (is_push),
        .flag_o  (is_flag),
        .abort_o (is_abort)
    );

    assign pk_clr = mode_chg || is_flag || is_abort;

    hdlc_bit_delay #(.DEPTH(HOLD)) i_delay (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pk_clr),
        .push     (is_push && collecting),
        .bit_i    (rx_bit),
        .commit_o (dly_commit),
        .bit_o    (dly_bit)
    );

    assign pk_shift = dly_commit || raw_bv;
    assign pk_bit   = in_raw ? rx_bit : dly_bit;

    hdlc_octet_pack #(.W(OCT_W)) i_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (pk_clr),
        .shift     (pk_shift),
        .bit_i     (pk_bit),
        .full_o    (pk_full),
        .octet_o   (pk_octet),
        .partial_o (pk_partial)
    );

    hdlc_crc_acc #(.W(CRC_W), .POLY(CRC_POLY), .INIT(CRC_INIT)) i_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (is_flag),
        .upd   (dly_commit),
        .bit_i (dly_bit),
        .crc_o (crc_val)
    );

    assign addr_hit = (pk_octet == match_addr) || (pk_octet == BCAST_ADDR);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RX_HUNT;
        else        st_q <= st_d;
    end

    // transitions
    always_comb begin
        st_d = st_q;
        if (mode_chg) begin
            st_d = raw_mode ? RX_RAW : RX_HUNT;          // to_raw / to_framed
        end else begin
            unique case (st_q)
                RX_HUNT: if (is_flag) st_d = RX_ADDR;     // open
                RX_ADDR: begin
                    if (is_flag)       st_d = RX_ADDR;    // restart
                    else if (is_abort) st_d = RX_HUNT;    // abort
                    else if (pk_full)  st_d = addr_hit ? RX_BODY : RX_SKIP; // hit / miss
                end
                RX_BODY, RX_SKIP: begin
                    if (is_flag)       st_d = RX_ADDR;    // restart
                    else if (is_abort) st_d = RX_HUNT;    // abort
                end
                RX_RAW:  st_d = RX_RAW;
                default: st_d = RX_HUNT;
            endcase
        end
    end

    // output decode
    always_comb begin
        nx_vld  = pk_full && (in_raw || (st_q == RX_BODY) ||
                              ((st_q == RX_ADDR) && addr_hit));
        nx_data = nx_vld ? pk_octet : '0;
        nx_end  = (st_q == RX_BODY) && (is_flag || is_abort);
        nx_disc = nx_end && (is_abort || pk_partial || (nb_q < NB_W'(MIN_OCTETS)));
        nx_ok   = nx_end && !nx_disc && (crc_val == CRC_GOOD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || pk_clr)
            nb_q <= '0;
        else if (nx_vld && !in_raw && (nb_q != NB_W'(MIN_OCTETS)))
            nb_q <= nb_q + 1'b1;
    end

    // output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_vld      <= 1'b0;
            byte_data     <= '0;
            frame_end     <= 1'b0;
            frame_crc_ok  <= 1'b0;
            frame_discard <= 1'b0;
        end else begin
            byte_vld      <= nx_vld;
            byte_data     <= nx_data;
            frame_end     <= nx_end;
            frame_crc_ok  <= nx_ok;
            frame_discard <= nx_disc;
        end
    end

endmodule

// File: rtl/hdlc_addr_rx_chk.sv
module hdlc_addr_rx_chk #(
    parameter int OCT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_bit_vld,
    input logic             raw_mode,
    input logic             byte_vld,
    input logic [OCT_W-1:0] byte_data,
    input logic             frame_end,
    input logic             frame_crc_ok,
    input logic             frame_discard
);
    AST_OK_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_crc_ok |-> frame_end);                               // R4
    AST_OK_DISC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> !(frame_crc_ok && frame_discard));           // R7
    AST_DISC_NEEDS_END: assert property (@(posedge clk) disable iff (!rst_n)
        frame_discard |-> frame_end);                              // R6
    AST_END_APART_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        !(byte_vld && frame_end));                                 // R2
    AST_DATA_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_vld |-> (byte_data == '0));                          // R2
    AST_RAW_NO_END: assert property (@(posedge clk) disable iff (!rst_n)
        $past(raw_mode) |-> !frame_end);                           // R10
    AST_QUIET_WITHOUT_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rx_bit_vld) |-> (!byte_vld && !frame_end));         // R12
endmodule

bind hdlc_addr_rx hdlc_addr_rx_chk #(.OCT_W(OCT_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_bit_vld    (rx_bit_vld),
    .raw_mode      (raw_mode),
    .byte_vld      (byte_vld),
    .byte_data     (byte_data),
    .frame_end     (frame_end),
    .frame_crc_ok  (frame_crc_ok),
    .frame_discard (frame_discard)
);

// File: tb/test_hdlc_addr_rx.sv
module test_hdlc_addr_rx;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       rx_bit = 1'b0, rx_bit_vld = 1'b0, raw_mode = 1'b0;
    logic [7:0] match_addr = 8'h5A;
    logic       byte_vld, frame_end, frame_crc_ok, frame_discard;
    logic [7:0] byte_data;

    hdlc_addr_rx i_hdlc_addr_rx (
        .clk(clk), .rst_n(rst_n), .rx_bit(rx_bit), .rx_bit_vld(rx_bit_vld),
        .raw_mode(raw_mode), .match_addr(match_addr), .byte_vld(byte_vld),
        .byte_data(byte_data), .frame_end(frame_end),
        .frame_crc_ok(frame_crc_ok), .frame_discard(frame_discard)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_chk = 0, n_err = 0;
    string cur_req = "R1";
    bit    md_r = 1'b0;
    logic [15:0] lcg = 16'hACE1;
    int    tx_ones = 0;
    logic [7:0] fr[$];
    logic [7:0] last_fcs_hi;

    // reference model state: 0 hunt, 1 address, 2 body, 3 skip, 4 raw
    int  m_st = 0, m_ones = 0, m_nb = 0;
    bit  pend[$];
    bit  acc[$];
    logic [15:0] m_crc = 16'hFFFF;
    logic       e_vld = 0, e_end = 0, e_ok = 0, e_disc = 0;
    logic [7:0] e_data = 0;

    int c_byte = 0, c_end = 0, c_ok = 0, c_disc = 0;
    logic [7:0] last_byte = 0;

    function automatic logic [15:0] crc_bit(logic [15:0] c, bit b);
        logic fb = c[0] ^ b;
        c = c >> 1;
        if (fb) c = c ^ 16'h8408;
        return c;
    endfunction

    function automatic logic [7:0] acc_octet();
        logic [7:0] v = 0;
        for (int i = 0; i < 8; i++) v[i] = acc[i];
        return v;
    endfunction

    function automatic void model_commit(bit c);
        logic [7:0] v;
        m_crc = crc_bit(m_crc, c);
        acc.push_back(c);
        if (acc.size() == 8) begin
            v = acc_octet();
            acc.delete();
            if (m_st == 1) begin
                if (v == match_addr || v == 8'hFF) begin
                    m_st = 2; e_vld = 1; e_data = v; m_nb++;
                end else m_st = 3;
            end else if (m_st == 2) begin
                e_vld = 1; e_data = v; m_nb++;
            end
        end
    endfunction

    function automatic void model_step(bit b, bit v, bit md);
        int kind;
        e_vld = 0; e_data = 0; e_end = 0; e_ok = 0; e_disc = 0;
        if (md != (m_st == 4)) begin
            m_st = md ? 4 : 0; m_ones = 0; m_nb = 0;
            pend.delete(); acc.delete();
            return;
        end
        if (!v) return;
        if (m_st == 4) begin
            acc.push_back(b);
            if (acc.size() == 8) begin e_vld = 1; e_data = acc_octet(); acc.delete(); end
            return;
        end
        if (b) begin
            if (m_ones < 5)       begin kind = 0; m_ones++; end
            else if (m_ones == 6) begin kind = 3; m_ones = 7; end
            else begin kind = 1; if (m_ones == 5) m_ones = 6; end
        end else begin
            if (m_ones == 6)      kind = 2;
            else if (m_ones == 5) kind = 1;
            else                  kind = 0;
            m_ones = 0;
        end
        if (kind == 2) begin
            if (m_st == 2) begin
                e_end = 1; e_disc = (acc.size() != 0) || (m_nb < 3);
                e_ok = !e_disc && (m_crc == 16'hF0B8);
            end
            m_st = 1; m_crc = 16'hFFFF; m_nb = 0; pend.delete(); acc.delete();
        end else if (kind == 3) begin
            if (m_st == 2) begin e_end = 1; e_disc = 1; end
            m_st = 0; m_nb = 0; pend.delete(); acc.delete();
        end else if (kind == 0 && (m_st == 1 || m_st == 2)) begin
            pend.push_back(b);
            if (pend.size() > 6) model_commit(pend.pop_front());
        end
    endfunction

    task automatic do_cycle(bit b, bit v);
        @(negedge clk);
        n_chk++;
        if ({byte_vld, byte_data, frame_end, frame_crc_ok, frame_discard} !==
            {e_vld, e_data, e_end, e_ok, e_disc}) begin
            n_err++;
            $display("FAIL %s cycle: actual vld=%0b data=%h end=%0b ok=%0b disc=%0b expected vld=%0b data=%h end=%0b ok=%0b disc=%0b",
                     cur_req, byte_vld, byte_data, frame_end, frame_crc_ok, frame_discard,
                     e_vld, e_data, e_end, e_ok, e_disc);
        end
        if (byte_vld) begin c_byte++; last_byte = byte_data; end
        if (frame_end) c_end++;
        if (frame_crc_ok) c_ok++;
        if (frame_discard) c_disc++;
        rx_bit = b; rx_bit_vld = v; raw_mode = md_r;
        model_step(b, v, md_r);
    endtask

    task automatic check(bit ok, string req, string what, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic clr_mon();
        c_byte = 0; c_end = 0; c_ok = 0; c_disc = 0;
    endtask

    task automatic expect_counts(string req, int eb, int ee, int eo, int ed);
        repeat (3) do_cycle(1'b0, 1'b0);
        if (eb >= 0) check(c_byte == eb, req, "octet count", c_byte, eb);
        check(c_end == ee,  req, "end count",     c_end,  ee);
        check(c_ok == eo,   req, "good count",    c_ok,   eo);
        check(c_disc == ed, req, "discard count", c_disc, ed);
        clr_mon();
    endtask

    // one valid bit, sometimes followed by an idle cycle carrying junk (R12)
    task automatic tx_bit(bit b);
        do_cycle(b, 1'b1);
        lcg = {lcg[14:0], lcg[15] ^ lcg[13] ^ lcg[12] ^ lcg[10]};
        if (lcg[3:2] == 2'b00) do_cycle(lcg[5], 1'b0);
    endtask

    task automatic send_flag();
        tx_bit(0); repeat (6) tx_bit(1); tx_bit(0);
        tx_ones = 0;
    endtask

    task automatic send_data_bit(bit b);
        tx_bit(b);
        if (b) begin
            tx_ones++;
            if (tx_ones == 5) begin tx_bit(0); tx_ones = 0; end   // R3 stuffing
        end else tx_ones = 0;
    endtask

    task automatic send_octet(logic [7:0] v);
        for (int i = 0; i < 8; i++) send_data_bit(v[i]);
    endtask

    task automatic send_body(logic [7:0] a, bit good);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        for (int i = 0; i < 8; i++) c = crc_bit(c, a[i]);
        foreach (fr[k]) for (int i = 0; i < 8; i++) c = crc_bit(c, fr[k][i]);
        fcs = ~c;
        if (!good) fcs[0] = ~fcs[0];
        send_octet(a);
        foreach (fr[k]) send_octet(fr[k]);
        send_octet(fcs[7:0]);
        send_octet(fcs[15:8]);
        last_fcs_hi = fcs[15:8];
    endtask

    task automatic send_frame(logic [7:0] a, bit good);
        send_flag(); send_body(a, good); send_flag();
    endtask

    task automatic send_raw_octet(logic [7:0] v);
        for (int i = 0; i < 8; i++) tx_bit(v[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL R1 watchdog expired: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) begin
            @(negedge clk);
            check({byte_vld, byte_data, frame_end, frame_crc_ok, frame_discard} == '0,
                  "R1", "outputs in reset", int'(byte_vld), 0);
        end
        rst_n = 1'b1;
        cur_req = "R1";
        repeat (4) do_cycle(1'b0, 1'b1);  // no flag yet: nothing expected
        repeat (16) tx_bit(1);            // idle marks
        expect_counts("R1", 0, 0, 0, 0);

        // R2 R3 R4: good frame, data forcing stuffing
        cur_req = "R2/R3/R4";
        fr = '{8'h11, 8'h7E, 8'hFF};
        send_frame(8'h5A, 1'b1);
        expect_counts("R2/R3/R4", 6, 1, 1, 0);
        check(last_byte == last_fcs_hi, "R2", "last octet is check high octet", last_byte, last_fcs_hi);

        // R4 wrong check value
        cur_req = "R4";
        send_frame(8'h5A, 1'b0);
        expect_counts("R4", 6, 1, 0, 0);

        // R5 mismatch and broadcast
        cur_req = "R5";
        send_frame(8'h33, 1'b1);
        expect_counts("R5", 0, 0, 0, 0);
        fr = '{8'hA5, 8'h00};
        send_frame(8'hFF, 1'b1);
        expect_counts("R5", 5, 1, 1, 0);

        // R9 shared flag between two frames
        cur_req = "R9";
        fr = '{8'h01};
        send_flag(); send_body(8'h5A, 1'b1); send_flag();
        fr = '{8'h02, 8'h03};
        send_body(8'h5A, 1'b1); send_flag();
        expect_counts("R9", 9, 2, 2, 0);

        // R6 abort in kept frame, abort in ignored frame, then recovery
        cur_req = "R6";
        send_flag(); send_octet(8'h5A); send_octet(8'h01); send_octet(8'h02);
        repeat (10) tx_bit(1);
        send_flag(); send_octet(8'h33); send_octet(8'h44);
        repeat (8) tx_bit(1);
        fr = '{8'hC3};
        send_frame(8'h5A, 1'b1);
        expect_counts("R6", -1, 2, 1, 1);

        // R7 too short, then misaligned
        cur_req = "R7";
        send_flag(); send_octet(8'h5A); send_octet(8'h01); send_flag();
        fr = '{8'h10, 8'h20, 8'h30};
        send_flag(); send_body(8'h5A, 1'b1);
        send_data_bit(0); send_data_bit(1); send_data_bit(0);
        send_flag();
        expect_counts("R7", -1, 2, 0, 2);

        // R8 flag before address is complete, and repeated flags
        cur_req = "R8";
        send_flag(); tx_bit(1); tx_bit(0); tx_bit(1); tx_bit(0); tx_bit(1);
        send_flag(); send_flag();
        expect_counts("R8", 0, 0, 0, 0);

        // R10 R11 raw mode: change cycle bit ignored, flag and ones packed as-is
        cur_req = "R10/R11";
        md_r = 1'b1; do_cycle(1'b1, 1'b1);
        send_raw_octet(8'h7E); send_raw_octet(8'hFF); send_raw_octet(8'h3C);
        expect_counts("R10", 3, 0, 0, 0);
        check(last_byte == 8'h3C, "R10", "raw last octet", last_byte, 8'h3C);

        // R11 partial raw octet dropped on switch to framed
        cur_req = "R11";
        repeat (5) tx_bit(1);
        md_r = 1'b0; do_cycle(1'b1, 1'b1);
        repeat (20) tx_bit(0);      // framed without flag: ignored
        expect_counts("R11", 0, 0, 0, 0);

        // R11 open frame dropped on switch to raw, no end marker
        fr = '{8'h55, 8'h66, 8'h77};
        send_flag(); send_body(8'h5A, 1'b1);
        md_r = 1'b1; do_cycle(1'b0, 1'b1);
        send_raw_octet(8'h81);
        expect_counts("R11", -1, 0, 0, 0);
        check(last_byte == 8'h81, "R11", "raw octet after switch", last_byte, 8'h81);

        // back to framed: a flag is required, then a good frame
        cur_req = "R11/R12";
        md_r = 1'b0; do_cycle(1'b0, 1'b1);
        fr = '{8'h9A};
        send_frame(8'h5A, 1'b1);
        expect_counts("R11/R12", 4, 1, 1, 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule